// File: doc/BRIEF.md
# Lockable external static memory controller

This block sits between a host and an external static memory bus with four chip selects. A host request carries an address, and the top two address bits choose the chip select. The controller then asserts that chip select, together with output enable for a read or write enable for a write. It holds them for a number of cycles taken from that chip select's configuration, and then returns a one-cycle done pulse.

Each chip select has an 8-bit configuration register. The register holds a wait code, a synchronous/asynchronous mode flag, a write-permit flag and a data-width code. A write to a chip select whose write-permit flag is clear is refused: no strobe reaches the memory, the host still gets its done pulse, and a sticky error flag is set.

The configuration registers sit on a simple 32-bit register bus behind a key register. They accept writes only after the key word has been written. Writing any other word to the key register locks them again.

Top module: `smem_ctrl`

## Requirements
- R1: After reset the configuration register at offset 0x00 reads 0x000000F0, those at 0x04, 0x08 and 0x0C read 0, and the key register (0x20) and the error register (0x24) read 0.
- R2: Writing 0x0000A05F to offset 0x20 unlocks the block, and the key register then reads 1 in bit 0. Writing any other word to 0x20 locks it, and it then reads 0.
- R3: While the block is locked, writes to offsets 0x00, 0x04, 0x08 and 0x0C leave the stored values unchanged. Reads always return the stored values.
- R4: While the block is unlocked, a write to offset 4*i stores wdata[7:0] for chip select i, and reads return it zero-extended. The fields are: bits 7:4 the wait code, bit 3 the sync flag, bit 2 the write-permit flag, and bits 1:0 the width (00 8-bit, 01 16-bit, 10 32-bit).
- R5: An access holds its chip select for min(wait code + 2, 16) consecutive cycles, so codes 0xE and 0xF both give 16.
- R6: mem_addr_i[27:26] = i selects chip select i (ext_cs_o bit i, active high). At most one ext_cs_o bit is ever high.
- R7: During a read, ext_oe_o is high for every cycle the chip select is high, and ext_we_o stays low.
- R8: During a permitted write, ext_we_o is high for every cycle the chip select is high, and ext_oe_o stays low.
- R9: A write to a chip select whose write-permit flag is 0 drives no chip select, output enable or write enable. mem_done_o pulses on the cycle after the request is accepted, and bit 0 of offset 0x24 becomes 1.
- R10: mem_done_o is high for exactly one cycle, the cycle after the last chip-select cycle. A request is accepted only when the controller is idle, which is never during an access or its done cycle.
- R11: During an access, ext_sync_o, ext_width_o and ext_addr_o (mem_addr_i[25:0]) reflect the configuration and address captured when the request was accepted. A configuration write during the access does not alter it. Outside an access these outputs are 0.
- R12: Writing a word with bit 0 set to offset 0x24 clears the error flag. If a refused write sets the flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_req_i | input | 1 | Register bus write strobe qualifier |
| reg_we_i | input | 1 | Register bus write (1) |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| mem_req_i | input | 1 | Host memory request |
| mem_we_i | input | 1 | Host request is a write |
| mem_addr_i | input | 28 | Host address; bits 27:26 select the chip select |
| mem_done_o | output | 1 | One-cycle completion pulse |
| ext_cs_o | output | 4 | Chip selects, active high, one-hot |
| ext_oe_o | output | 1 | Output enable (reads) |
| ext_we_o | output | 1 | Write enable (permitted writes) |
| ext_sync_o | output | 1 | Sync mode of the active chip select |
| ext_width_o | output | 2 | Width code of the active chip select |
| ext_addr_o | output | 26 | Address within the selected region |

## Verification
The bench targets the wait-code saturation at 0xE and 0xF. A design that wrapped or extended the count would hold the chip select for the wrong number of cycles. It checks that a locked write is dropped: a design that stored it would read back a changed value. It also checks a refused write, where a design driving a write strobe or skipping the done pulse would either corrupt the memory or hang the host.

The bench changes a configuration register while an access is in flight, holds a request high across two back-to-back accesses, and clears the error flag in the same cycle that a refused write sets it. A design that read the live configuration, accepted a request during its done cycle, or let the clear win would drift from the cycle model.

// File: rtl/smem_pkg.sv
package smem_pkg;
  localparam int CFG_W    = 8;
  localparam int MIN_HOLD = 2;
  localparam int MAX_HOLD = 16;
  localparam int KEY_OFS  = 'h20;
  localparam int ERR_OFS  = 'h24;
  localparam logic [31:0] UNLOCK_KEY = 32'h0000_A05F;
  localparam logic [CFG_W-1:0] CS0_RST = 8'hF0;

  typedef struct packed {
    logic [3:0] wait_code;
    logic       sync;
    logic       wr_en;
    logic [1:0] width;
  } cs_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} seq_st_e;
endpackage

// File: rtl/smem_regs.sv
module smem_regs
  import smem_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int RAW    = 6,
  parameter int DW     = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [RAW-1:0]         addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  input  logic                   err_set_i,
  output cs_cfg_t [NUM_CS-1:0]   cfg_o
);
  logic unl_q, err_q;
  logic wr;
  logic key_wr, err_wr;
  logic [NUM_CS-1:0] cfg_wr;
  cs_cfg_t [NUM_CS-1:0] cfg_q;

  assign wr     = req_i && we_i;
  assign key_wr = wr && (addr_i == RAW'(KEY_OFS));
  assign err_wr = wr && (addr_i == RAW'(ERR_OFS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     unl_q <= 1'b0;
    else if (key_wr) unl_q <= (wdata_i == DW'(UNLOCK_KEY));
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    err_q <= 1'b0;
    else if (err_set_i)             err_q <= 1'b1;
    else if (err_wr && wdata_i[0])  err_q <= 1'b0;
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cfg
    localparam logic [CFG_W-1:0] RST_V = (i == 0) ? CS0_RST : '0;
    assign cfg_wr[i] = wr && (addr_i == RAW'(i * 4));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 cfg_q[i] <= cs_cfg_t'(RST_V);
      else if (cfg_wr[i] && unl_q) cfg_q[i] <= cs_cfg_t'(wdata_i[CFG_W-1:0]);
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CS; i++)
      if (addr_i == RAW'(i * 4)) rdata_o[CFG_W-1:0] = cfg_q[i];
    if (addr_i == RAW'(KEY_OFS)) rdata_o[0] = unl_q;
    if (addr_i == RAW'(ERR_OFS)) rdata_o[0] = err_q;
  end

  assign cfg_o = cfg_q;

  assert_locked_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unl_q && |cfg_wr) |=> $stable(cfg_q));
  assert_key_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && wdata_i == DW'(UNLOCK_KEY)) |=> unl_q);
  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set_i |=> err_q);
endmodule

// File: rtl/smem_cs_dec.sv
module smem_cs_dec #(
  parameter int NUM_CS = 4,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic              en_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [NUM_CS-1:0] cs_o
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_o[i] = en_i && (sel_i == SEL_W'(i));
  end
endmodule

// File: rtl/smem_seq.sv
module smem_seq
  import smem_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int AW       = 28,
  parameter int MIN_CYC  = MIN_HOLD,
  parameter int MAX_CYC  = MAX_HOLD,
  localparam int SEL_W   = $clog2(NUM_CS),
  localparam int OFS_W   = AW - SEL_W,
  localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mem_req_i,
  input  logic                 mem_we_i,
  input  logic [AW-1:0]        mem_addr_i,
  input  cs_cfg_t [NUM_CS-1:0] cfg_i,
  output logic                 done_o,
  output logic                 err_set_o,
  output logic                 busy_o,
  output logic [SEL_W-1:0]     sel_o,
  output logic                 oe_o,
  output logic                 we_o,
  output logic                 sync_o,
  output logic [1:0]           width_o,
  output logic [OFS_W-1:0]     addr_o
);
  seq_st_e st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q, req_sel;
  logic we_q;
  cs_cfg_t lat_q, cur_cfg;
  logic [OFS_W-1:0] addr_q;
  logic accept, refuse;

  function automatic logic [CNT_W-1:0] hold_cycles(logic [3:0] code);
    int v;
    v = int'(code) + MIN_CYC;
    if (v > MAX_CYC) v = MAX_CYC;
    return CNT_W'(v);
  endfunction

  assign req_sel   = mem_addr_i[AW-1 -: SEL_W];
  assign cur_cfg   = cfg_i[req_sel];
  assign accept    = (st_q == ST_IDLE) && mem_req_i;
  assign refuse    = mem_we_i && !cur_cfg.wr_en;
  assign err_set_o = accept && refuse;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sel_q  <= '0;
      we_q   <= 1'b0;
      lat_q  <= '0;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (mem_req_i) begin
          sel_q  <= req_sel;
          we_q   <= mem_we_i;
          lat_q  <= cur_cfg;
          addr_q <= mem_addr_i[OFS_W-1:0];
          cnt_q  <= hold_cycles(cur_cfg.wait_code) - 1'b1;
          st_q   <= refuse ? ST_DONE : ST_BUSY;
        end
        ST_BUSY: begin
          if (cnt_q == '0) st_q <= ST_DONE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q == ST_BUSY);
  assign done_o  = (st_q == ST_DONE);
  assign sel_o   = sel_q;
  assign oe_o    = busy_o && !we_q;
  assign we_o    = busy_o && we_q;
  assign sync_o  = busy_o && lat_q.sync;
  assign width_o = busy_o ? lat_q.width : 2'b00;
  assign addr_o  = busy_o ? addr_q : '0;

  // length of the current strobe run, for the checks below
  logic [CNT_W:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  assert_run_max_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= (CNT_W+1)'(MAX_CYC));
  assert_run_min_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q >= (CNT_W+1)'(MIN_CYC));
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_refuse_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set_o |=> (done_o && !busy_o && !we_o));
  assert_strobe_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(oe_o && we_o));
endmodule

// File: rtl/smem_ctrl.sv
module smem_ctrl
  import smem_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int AW     = 28,
  parameter int RAW    = 6,
  parameter int DW     = 32,
  localparam int SEL_W = $clog2(NUM_CS),
  localparam int OFS_W = AW - SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [RAW-1:0]    reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              mem_req_i,
  input  logic              mem_we_i,
  input  logic [AW-1:0]     mem_addr_i,
  output logic              mem_done_o,
  output logic [NUM_CS-1:0] ext_cs_o,
  output logic              ext_oe_o,
  output logic              ext_we_o,
  output logic              ext_sync_o,
  output logic [1:0]        ext_width_o,
  output logic [OFS_W-1:0]  ext_addr_o
);
  cs_cfg_t [NUM_CS-1:0] cfg;
  logic err_set, busy;
  logic [SEL_W-1:0] sel;

  smem_regs #(.NUM_CS(NUM_CS), .RAW(RAW), .DW(DW)) u_regs (
    .clk_i, .rst_ni,
    .req_i(reg_req_i), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .err_set_i(err_set), .cfg_o(cfg)
  );

  smem_seq #(.NUM_CS(NUM_CS), .AW(AW)) u_seq (
    .clk_i, .rst_ni,
    .mem_req_i, .mem_we_i, .mem_addr_i, .cfg_i(cfg),
    .done_o(mem_done_o), .err_set_o(err_set), .busy_o(busy), .sel_o(sel),
    .oe_o(ext_oe_o), .we_o(ext_we_o), .sync_o(ext_sync_o),
    .width_o(ext_width_o), .addr_o(ext_addr_o)
  );

  smem_cs_dec #(.NUM_CS(NUM_CS)) u_dec (
    .en_i(busy), .sel_i(sel), .cs_o(ext_cs_o)
  );

  assert_one_cs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ext_cs_o));
  assert_strobe_has_cs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_oe_o || ext_we_o) |-> (|ext_cs_o));
endmodule

// File: tb/sim_smem_ctrl.sv
`timescale 1ns/1ps
module sim_smem_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_req = 0, reg_we = 0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req = 0, mem_we = 0;
  logic [27:0] mem_addr = '0;
  logic mem_done, ext_oe, ext_we, ext_sync;
  logic [3:0] ext_cs;
  logic [1:0] ext_width;
  logic [25:0] ext_addr;

  int checks = 0, fails = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  smem_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_i(mem_req), .mem_we_i(mem_we), .mem_addr_i(mem_addr),
    .mem_done_o(mem_done), .ext_cs_o(ext_cs), .ext_oe_o(ext_oe),
    .ext_we_o(ext_we), .ext_sync_o(ext_sync), .ext_width_o(ext_width),
    .ext_addr_o(ext_addr)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h @%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_cfg[4];
  bit m_unl, m_err, m_done, m_we, m_sync;
  int m_left, m_cs, m_width, m_addr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = '{'hF0, 0, 0, 0};
      m_unl = 0; m_err = 0; m_done = 0; m_left = 0;
      m_cs = 0; m_we = 0; m_sync = 0; m_width = 0; m_addr = 0;
    end else begin
      bit set_e, clr_e;
      set_e = 0; clr_e = 0;
      if (m_done) m_done = 0;
      else if (m_left > 0) begin
        m_left--;
        if (m_left == 0) m_done = 1;
      end else if (mem_req) begin
        int c, s;
        s = int'(mem_addr[27:26]);
        c = m_cfg[s];
        if (mem_we && ((c & 4) == 0)) begin
          m_done = 1; set_e = 1;
        end else begin
          m_left = (c >> 4) + 2;
          if (m_left > 16) m_left = 16;
          m_cs = s; m_we = mem_we; m_sync = (c & 8) != 0;
          m_width = c & 3; m_addr = int'(mem_addr[25:0]);
        end
      end
      if (reg_req && reg_we) begin
        if (reg_addr == 6'h20) m_unl = (reg_wdata == 32'h0000A05F);
        else if (reg_addr == 6'h24) clr_e = reg_wdata[0];
        else if (reg_addr[1:0] == 0 && reg_addr < 6'h10 && m_unl)
          m_cfg[reg_addr[3:2]] = int'(reg_wdata[7:0]);
      end
      if (clr_e) m_err = 0;
      if (set_e) m_err = 1;
    end
  end

  // compare every cycle, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !ended) begin
      logic [3:0] e_cs;
      bit act;
      act = m_left > 0;
      e_cs = act ? 4'(1 << m_cs) : 4'h0;
      chk(ext_cs == e_cs, "R6 cs", 32'(ext_cs), 32'(e_cs));
      chk(ext_oe == (act && !m_we), "R7 oe", 32'(ext_oe), 32'(act && !m_we));
      chk(ext_we == (act && m_we), "R8 we", 32'(ext_we), 32'(act && m_we));
      chk(mem_done == m_done, "R10 done", 32'(mem_done), 32'(m_done));
      chk(ext_sync == (act && m_sync), "R11 sync", 32'(ext_sync), 32'(act && m_sync));
      chk(32'(ext_width) == (act ? m_width : 0), "R11 width", 32'(ext_width), act ? m_width : 0);
      chk(32'(ext_addr) == (act ? m_addr : 0), "R11 addr", 32'(ext_addr), act ? m_addr : 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic reg_wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
  endtask

  task automatic reg_rd(logic [5:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic mem_go(bit we, logic [27:0] a, int exp_len, string tag);
    int n = 0, g = 0;
    @(negedge clk);
    mem_req = 1; mem_we = we; mem_addr = a;
    @(negedge clk);
    mem_req = 0;
    while (!mem_done && g < 40) begin
      if (|ext_cs) n++;
      @(negedge clk);
      g++;
    end
    chk(mem_done == 1'b1, {tag, " done seen"}, 32'(mem_done), 1);
    chk(n == exp_len, {tag, " strobe length"}, n, exp_len);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    ended = 1;
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    reg_rd(6'h00, 32'hF0, "R1 cfg0");
    reg_rd(6'h04, 32'h00, "R1 cfg1");
    reg_rd(6'h0C, 32'h00, "R1 cfg3");
    reg_rd(6'h20, 32'h0, "R1 key");
    reg_rd(6'h24, 32'h0, "R1 err");
    // R5/R7 default cs0: code F saturates at 16
    mem_go(0, 28'h0000_040, 16, "R5 cs0 code F");
    // R3 locked write dropped
    reg_wr(6'h04, 32'h3D);
    reg_rd(6'h04, 32'h00, "R3 locked cfg1");
    // R2 key handling
    reg_wr(6'h20, 32'h0000_A05E);
    reg_rd(6'h20, 32'h0, "R2 wrong key");
    reg_wr(6'h20, 32'h0000_A05F);
    reg_rd(6'h20, 32'h1, "R2 unlocked");
    // R4 programming
    reg_wr(6'h04, 32'h3D);
    reg_wr(6'h08, 32'hE2);
    reg_wr(6'h0C, 32'hFFFF_FF06);
    reg_rd(6'h04, 32'h3D, "R4 cfg1");
    reg_rd(6'h08, 32'hE2, "R4 cfg2");
    reg_rd(6'h0C, 32'h06, "R4 cfg3 upper bits");
    // R8 permitted write on cs1 (5 cycles, sync, 16-bit)
    mem_go(1, 28'h400_0123, 5, "R8 cs1 write");
    // R7 read on cs3 (2 cycles, 32-bit)
    mem_go(0, 28'hC00_0010, 2, "R7 cs3 read");
    // R5 code E gives 16
    mem_go(0, 28'h800_0001, 16, "R5 cs2 code E");
    // R9 refused write on cs2
    mem_go(1, 28'h800_0002, 0, "R9 refused");
    reg_rd(6'h24, 32'h1, "R9 err set");
    // R12 clear
    reg_wr(6'h24, 32'h1);
    reg_rd(6'h24, 32'h0, "R12 err cleared");
    // R12 set wins over clear in the same cycle
    @(negedge clk);
    mem_req = 1; mem_we = 1; mem_addr = 28'h800_0003;
    reg_req = 1; reg_we = 1; reg_addr = 6'h24; reg_wdata = 32'h1;
    @(negedge clk);
    mem_req = 0; reg_req = 0; reg_we = 0;
    repeat (2) @(negedge clk);
    reg_rd(6'h24, 32'h1, "R12 set beats clear");
    reg_wr(6'h24, 32'h1);
    // R11 config change mid-access
    @(negedge clk);
    mem_req = 1; mem_we = 0; mem_addr = 28'h400_0abc;
    @(negedge clk);
    mem_req = 0;
    reg_wr(6'h04, 32'h05);
    repeat (8) @(negedge clk);
    reg_rd(6'h04, 32'h05, "R11 cfg1 updated");
    mem_go(0, 28'h400_0004, 2, "R11 new cfg used");
    // R10 request held high across two accesses
    @(negedge clk);
    mem_req = 1; mem_we = 1; mem_addr = 28'hC00_0020;
    repeat (12) @(negedge clk);
    mem_req = 0;
    repeat (4) @(negedge clk);
    // R2/R3 relock then write ignored
    reg_wr(6'h20, 32'h1234);
    reg_rd(6'h20, 32'h0, "R2 relocked");
    reg_wr(6'h00, 32'h00);
    reg_rd(6'h00, 32'hF0, "R3 relocked cfg0");
    repeat (3) @(negedge clk);
    ended = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule